// File: doc/BRIEF.md
# DQ Mask and Clock-Suspend Data Pipeline

This block sits on the device side of a synchronous DRAM data bus. It takes the read beats coming out of the array and the write beats coming in from the bus. It decides, cycle by cycle, whether a read beat reaches the DQ pins and whether a write beat is committed to the array. Two controls act on it: a byte mask input, and a clock-enable input that can freeze the internal clock.

The mask acts on the two directions with different delays. For reads, a mask seen on an internal clock edge blanks the beat that is driven two internal edges later. For writes, a mask seen together with a write beat blocks that same beat. When clock-enable is sampled low, the internal clock stops on the following edge. While it is stopped, the read output holds its value, no write strobe is issued, and the mask history and burst position hold their state. The block does not decode commands, generate CAS latency or contain the array.

The clock-enable handling is a two-state machine. In `ST_RUN` every edge is an internal clock edge. In `ST_HOLD` edges are swallowed. Transition RUN_TO_HOLD is taken on an edge where clock-enable is sampled low. Transition HOLD_TO_RUN is taken on an edge where it is sampled high. Staying in either state is the self-loop for an unchanged clock-enable. Reset enters `ST_RUN`.

Top module: `dq_mask_suspend`

## Requirements
- R1: After reset, and until the first internal edge changes them, `dq_oe_o`, `dq_o` and `arr_we_o` are 0.
- R2: On an internal edge where `rd_valid_i` is 1 and the read mask does not apply, `dq_oe_o` becomes 1 and `dq_o` takes `rd_data_i`, from that edge until the next one.
- R3: A `dqm_i` of 1 sampled on internal edge k blanks the read beat taken on internal edge k+2: `dq_oe_o` becomes 0 and `dq_o` becomes 0. It has no effect on the beats taken on internal edges k and k+1.
- R4: On an internal edge where `wr_valid_i` is 1 and `dqm_i` is 0, `arr_we_o` is 1 for one cycle and `arr_wdata_o` carries `wr_data_i`.
- R5: On an internal edge where `dqm_i` is 1, `arr_we_o` is 0 afterwards even if `wr_valid_i` is 1, and `arr_wdata_o` keeps its previous value.
- R6: `cke_i` sampled 0 on edge k makes edge k+1 a swallowed edge, while edge k itself still follows the previous sample. `cke_i` sampled 1 on edge j makes edge j+1 an internal edge.
- R7: On a swallowed edge, `dq_oe_o`, `dq_o` and `arr_wdata_o` hold their values and `arr_we_o` becomes 0.
- R8: `dqm_i` and the other inputs are ignored on swallowed edges, and the read-mask delay of R3 is counted in internal edges only.
- R9: On an internal edge where `rd_valid_i` is 0, `dq_oe_o` becomes 0 and `dq_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock enable; 0 freezes the internal clock one edge later |
| dqm_i | input | 1 | Data mask: read blank (delay 2) and write block (delay 0) |
| rd_valid_i | input | 1 | A read beat from the array is present |
| rd_data_i | input | DW | Read beat data from the array |
| wr_valid_i | input | 1 | A write beat from the bus is present |
| wr_data_i | input | DW | Write beat data from the bus |
| dq_oe_o | output | 1 | DQ output enable |
| dq_o | output | DW | DQ output data, 0 when not enabled |
| arr_we_o | output | 1 | Per-beat write strobe toward the array |
| arr_wdata_o | output | DW | Data committed with the write strobe |

## Verification
The hardest case to reach is a read mask that is raised just before or during a freeze. The blanking must then land on the second internal edge after the mask, not on the second bus edge, and masks raised during the freeze must be dropped. Random stimulus alone rarely gives that alignment. Directed sequences therefore raise `dqm_i` one edge before clock-enable falls, and hold it high through the freeze. A further directed case pulses clock-enable low for a single edge in the middle of a write burst. A cycle-accurate model in the bench, written from the requirements, follows the whole random run.

// File: rtl/dq_mask_pkg.sv
package dq_mask_pkg;

    // Internal clock state: edges pass in ST_RUN, are swallowed in ST_HOLD.
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } clk_state_e;

    localparam int unsigned DEF_DW       = 8;
    localparam int unsigned DEF_RD_DELAY = 2;

endpackage

// File: rtl/dq_clk_gate.sv
module dq_clk_gate
    import dq_mask_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke_i,
    output logic adv_o
);

    clk_state_e state_q;
    clk_state_e state_d;

    // Next state: the sampled clock-enable decides the following edge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (!cke_i) state_d = ST_HOLD;  // RUN_TO_HOLD
            ST_HOLD: if (cke_i)  state_d = ST_RUN;   // HOLD_TO_RUN
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Output process: internal edge qualifier.
    always_comb begin
        unique case (state_q)
            ST_RUN:  adv_o = 1'b1;
            ST_HOLD: adv_o = 1'b0;
            default: adv_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dq_rd_path.sv
module dq_rd_path #(
    parameter int unsigned DW       = 8,
    parameter int unsigned RD_DELAY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic          dqm_i,
    input  logic          rd_valid_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          dq_oe_o,
    output logic [DW-1:0] dq_o
);

    localparam int unsigned SR_W = (RD_DELAY < 1) ? 1 : RD_DELAY;

    logic [SR_W-1:0] mask_sr;
    logic            mask_now;

    generate
        if (SR_W == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n)     mask_sr <= '0;
                else if (adv_i) mask_sr <= dqm_i;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (!rst_n)     mask_sr <= '0;
                else if (adv_i) mask_sr <= {mask_sr[SR_W-2:0], dqm_i};
            end
        end
    endgenerate

    // Mask sampled RD_DELAY internal edges before this one.
    assign mask_now = mask_sr[SR_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe_o <= 1'b0;
            dq_o    <= '0;
        end else if (adv_i) begin
            dq_oe_o <= rd_valid_i && !mask_now;
            dq_o    <= (rd_valid_i && !mask_now) ? rd_data_i : '0;
        end
    end

endmodule

// File: rtl/dq_wr_path.sv
module dq_wr_path #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic          dqm_i,
    input  logic          wr_valid_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          arr_we_o,
    output logic [DW-1:0] arr_wdata_o
);

    logic commit;

    // Zero-delay mask: the mask travels with its own beat.
    assign commit = adv_i && wr_valid_i && !dqm_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_we_o    <= 1'b0;
            arr_wdata_o <= '0;
        end else begin
            arr_we_o <= commit;
            if (commit) arr_wdata_o <= wr_data_i;
        end
    end

endmodule

// File: rtl/dq_mask_suspend.sv
module dq_mask_suspend
    import dq_mask_pkg::*;
#(
    parameter int unsigned DW       = DEF_DW,
    parameter int unsigned RD_DELAY = DEF_RD_DELAY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cke_i,
    input  logic          dqm_i,
    input  logic          rd_valid_i,
    input  logic [DW-1:0] rd_data_i,
    input  logic          wr_valid_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          dq_oe_o,
    output logic [DW-1:0] dq_o,
    output logic          arr_we_o,
    output logic [DW-1:0] arr_wdata_o
);

    logic adv;

    dq_clk_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .cke_i (cke_i),
        .adv_o (adv)
    );

    dq_rd_path #(.DW(DW), .RD_DELAY(RD_DELAY)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .dqm_i      (dqm_i),
        .rd_valid_i (rd_valid_i),
        .rd_data_i  (rd_data_i),
        .dq_oe_o    (dq_oe_o),
        .dq_o       (dq_o)
    );

    dq_wr_path #(.DW(DW)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (adv),
        .dqm_i       (dqm_i),
        .wr_valid_i  (wr_valid_i),
        .wr_data_i   (wr_data_i),
        .arr_we_o    (arr_we_o),
        .arr_wdata_o (arr_wdata_o)
    );

endmodule

// File: rtl/dq_mask_suspend_chk.sv
module dq_mask_suspend_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adv,
    input logic          cke_i,
    input logic          dqm_i,
    input logic          rd_valid_i,
    input logic          wr_valid_i,
    input logic [DW-1:0] wr_data_i,
    input logic          dq_oe_o,
    input logic [DW-1:0] dq_o,
    input logic          arr_we_o,
    input logic [DW-1:0] arr_wdata_o
);

    p_read_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !rd_valid_i) |=> (!dq_oe_o && dq_o == '0));

    p_write_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && wr_valid_i && !dqm_i) |=> (arr_we_o && arr_wdata_o == $past(wr_data_i)));

    p_write_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && dqm_i) |=> (!arr_we_o && $stable(arr_wdata_o)));

    p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(dq_oe_o) && $stable(dq_o) && !arr_we_o && $stable(arr_wdata_o)));

    p_enter_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_i |=> !adv);

    p_exit_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cke_i |=> adv);

    p_oe_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe_o |-> (dq_o == '0));

endmodule

bind dq_mask_suspend dq_mask_suspend_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv         (adv),
    .cke_i       (cke_i),
    .dqm_i       (dqm_i),
    .rd_valid_i  (rd_valid_i),
    .wr_valid_i  (wr_valid_i),
    .wr_data_i   (wr_data_i),
    .dq_oe_o     (dq_oe_o),
    .dq_o        (dq_o),
    .arr_we_o    (arr_we_o),
    .arr_wdata_o (arr_wdata_o)
);

// File: tb/sim_dq_mask_suspend.sv
module sim_dq_mask_suspend;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_i = 1'b1;
    logic          dqm_i = 1'b0;
    logic          rd_valid_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          wr_valid_i = 1'b0;
    logic [DW-1:0] wr_data_i = '0;
    logic          dq_oe_o;
    logic [DW-1:0] dq_o;
    logic          arr_we_o;
    logic [DW-1:0] arr_wdata_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dq_mask_suspend #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .dqm_i(dqm_i),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
        .dq_oe_o(dq_oe_o), .dq_o(dq_o),
        .arr_we_o(arr_we_o), .arr_wdata_o(arr_wdata_o)
    );

    // Reference state, built from the requirements.
    bit            m_run;
    bit            m_d1, m_d2;
    bit            m_oe, m_we;
    logic [DW-1:0] m_dq, m_wd;
    string         rd_tag = "R1";
    string         wr_tag = "R1";
    string         force_tag = "";

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        string rt, wt;
        rt = (force_tag != "") ? force_tag : rd_tag;
        wt = (force_tag != "") ? force_tag : wr_tag;
        chk(dq_oe_o == m_oe, rt, "dq_oe_o", int'(dq_oe_o), int'(m_oe));
        chk(dq_o == m_dq, rt, "dq_o", int'(dq_o), int'(m_dq));
        chk(arr_we_o == m_we, wt, "arr_we_o", int'(arr_we_o), int'(m_we));
        chk(arr_wdata_o == m_wd, wt, "arr_wdata_o", int'(arr_wdata_o), int'(m_wd));
    endtask

    // Predict the outputs after the next rising edge from the current inputs.
    task automatic step();
        if (!rst_n) begin
            m_run = 1; m_d1 = 0; m_d2 = 0;
            m_oe = 0; m_dq = '0; m_we = 0; m_wd = '0;
            rd_tag = "R1"; wr_tag = "R1";
        end else if (m_run) begin
            m_oe   = rd_valid_i && !m_d2;
            m_dq   = m_oe ? rd_data_i : '0;
            rd_tag = !rd_valid_i ? "R9" : (m_d2 ? "R3" : "R2");
            m_we   = wr_valid_i && !dqm_i;
            if (m_we) m_wd = wr_data_i;
            wr_tag = dqm_i ? "R5" : "R4";
            m_d2 = m_d1;
            m_d1 = dqm_i;
            m_run = cke_i;
        end else begin
            m_we = 0;
            rd_tag = "R7"; wr_tag = "R7";
            m_run = cke_i;
        end
    endtask

    // One bus cycle: check the outputs, apply new inputs, predict.
    task automatic cyc(input bit cke, input bit dqm, input bit rv,
                       input logic [DW-1:0] rd, input bit wv,
                       input logic [DW-1:0] wd);
        @(negedge clk);
        compare();
        cke_i = cke; dqm_i = dqm; rd_valid_i = rv; rd_data_i = rd;
        wr_valid_i = wv; wr_data_i = wd;
        step();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst_n = 0;
        step();
        repeat (3) begin
            @(negedge clk);
            force_tag = "R1";
            compare();
            step();
        end
        @(negedge clk);
        rst_n = 1;
        step();
        force_tag = "R1";
        cyc(1, 0, 0, 8'h00, 0, 8'h00);
        force_tag = "";

        // R2 R3: read burst, mask on beat 1 blanks beat 3 only.
        force_tag = "R3";
        cyc(1, 0, 1, 8'h11, 0, 0);
        cyc(1, 1, 1, 8'h22, 0, 0);
        cyc(1, 0, 1, 8'h33, 0, 0);
        cyc(1, 0, 1, 8'h44, 0, 0);
        cyc(1, 0, 1, 8'h55, 0, 0);
        // R8: mask raised just before freeze and held through it.
        force_tag = "R8";
        cyc(1, 1, 1, 8'h61, 0, 0);
        cyc(0, 1, 1, 8'h62, 0, 0);
        cyc(0, 1, 1, 8'h62, 0, 0);
        cyc(1, 1, 1, 8'h62, 0, 0);
        cyc(1, 0, 1, 8'h63, 0, 0);
        cyc(1, 0, 1, 8'h64, 0, 0);
        cyc(1, 0, 1, 8'h65, 0, 0);
        // R6 R7: single-edge freeze in a write burst, R5 mask on a beat.
        force_tag = "R6";
        cyc(1, 0, 0, 0, 1, 8'hA1);
        cyc(0, 0, 0, 0, 1, 8'hA2);
        cyc(1, 0, 0, 0, 1, 8'hA2);
        cyc(1, 1, 0, 0, 1, 8'hA3);
        cyc(1, 0, 0, 0, 1, 8'hA4);
        cyc(1, 0, 0, 0, 0, 8'h00);
        force_tag = "R7";
        cyc(0, 0, 1, 8'hB0, 0, 0);
        cyc(0, 0, 1, 8'hB1, 1, 8'hB9);
        cyc(1, 0, 1, 8'hB2, 0, 0);
        cyc(1, 0, 0, 8'h00, 0, 0);
        force_tag = "";

        // Constrained random mix.
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 5) != 0, ($urandom % 10) < 3, ($urandom % 10) < 7,
                DW'($urandom), ($urandom % 10) < 6, DW'($urandom));
        end
        @(negedge clk);
        compare();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule